// File: doc/BRIEF.md
# Option Register Guard with Read-Protection Decode

This block keeps the option configuration of a flash controller and turns its protection byte into a read-protection level. Software reaches it through a small register bus with four word addresses: a key port, an option control register, a status register and a view register. The option control register accepts no writes until two fixed key words have arrived in the right order. Any other key traffic bars it until the next system reset.

Once the register is unlocked, software writes pending option values. Setting the start bit launches a programming pass of fixed length, and busy stays high for that pass. At the end of the pass the pending values go into a store that survives a system reset but not a power-on reset, and the register locks again. The active copy, which drives the debug gates, is reloaded from the store only while the system reset is held. A stored sealed level can never be lowered.

Top module: `optg_ctrl`

## Requirements
- R1: The control register unlocks only after a write of 0x08192A3B to the key port (address 0) and then a write of 0x4C5D6E7F. A first key alone does not unlock it, and a wrong second key does not unlock it.
- R2: A key write that breaks the sequence bars the register until the next system reset. So does any key write while the register is unlocked. Status bit 2 shows the barred state. Control writes made while the register is locked or barred change nothing.
- R3: A control write (address 1) sets the pending options from bits [15:0]. The store changes only when bit 31 of that write is set. Busy (status bit 0) is then high for exactly PROG_CYCLES cycles, and the store takes the pending value on the cycle busy falls.
- R4: While busy is high, control writes and start requests are ignored.
- R5: The register locks again when a programming pass completes. Status bit 1 reads 0, and later control writes are ignored.
- R6: The level is decoded from option bits [7:0]. 0xAA gives level 0, 0xCC gives level 2, and every other value gives level 1. The debug port is enabled below level 2. Debug reads of flash are enabled only at level 0.
- R7: The active options, the level and the debug gates change only while the system reset is held. During that reset they load from the store.
- R8: When the stored protection byte is 0xCC, a commit keeps it at 0xCC. The other option bits still commit.
- R9: A power-on reset sets the store, the pending value and the active value to OPT_DEFAULT.
- R10: Reads are as follows. Address 1 returns the pending options. Address 2 returns the active level in bits [5:4]. Address 3 returns the active options in [15:0] and the stored options in [31:16]. After a system reset the pending options equal the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; also clears the store |
| sys_rst_n | input | 1 | System reset, active low, synchronous; reloads the active options |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| busy | output | 1 | Programming pass in progress |
| prot_level | output | 2 | Active read-protection level (0, 1, 2) |
| dbg_port_en | output | 1 | Debug port enable |
| dbg_flash_en | output | 1 | Debug access to flash enable |

## Verification
The bench builds the block with PROG_CYCLES = 5, OPT_W = 16 and OPT_DEFAULT = 0x5AAA. With a short pass, the bench can read status on every cycle of the pass, put a start request in the middle of it, and see the exact cycle on which busy falls. Because the default is level 0, every level can be reached from power-on. A stored 0xCC can be overwritten to show that the seal holds, and a further power-on reset brings the default back, so the catch-all byte and the return to level 0 can both be checked.

// File: rtl/optg_pkg.sv
`timescale 1ns/1ps
package optg_pkg;

  localparam logic [31:0] KEY_FIRST  = 32'h0819_2A3B;
  localparam logic [31:0] KEY_SECOND = 32'h4C5D_6E7F;

  localparam logic [7:0] PROT_OPEN   = 8'hAA;
  localparam logic [7:0] PROT_SEALED = 8'hCC;

  localparam logic [1:0] RA_KEY  = 2'd0;
  localparam logic [1:0] RA_CTRL = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam logic [1:0] RA_VIEW = 2'd3;

  localparam int START_BIT = 31;

  typedef enum logic [1:0] {
    LVL_OPEN    = 2'd0,
    LVL_GUARDED = 2'd1,
    LVL_SEALED  = 2'd2
  } prot_lvl_e;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2,
    KS_BARRED = 2'd3
  } key_state_e;

  // Two exact codes and a catch-all for everything else
  function automatic prot_lvl_e decode_prot(input logic [7:0] b);
    if (b == PROT_OPEN)        return LVL_OPEN;
    else if (b == PROT_SEALED) return LVL_SEALED;
    else                       return LVL_GUARDED;
  endfunction

  // A sealed byte never changes; otherwise the request wins
  function automatic logic [7:0] merge_prot(input logic [7:0] cur,
                                            input logic [7:0] req);
    return (decode_prot(cur) == LVL_SEALED) ? cur : req;
  endfunction

endpackage

// File: rtl/optg_key_seq.sv
`timescale 1ns/1ps
module optg_key_seq
  import optg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  input  logic        prog_done,
  output logic        unlocked,
  output logic        barred
);

  key_state_e st, st_nx;

  always_comb begin
    st_nx = st;
    if (key_wr) begin
      unique case (st)
        KS_LOCKED: st_nx = (key_data == KEY_FIRST)  ? KS_HALF : KS_BARRED;
        KS_HALF:   st_nx = (key_data == KEY_SECOND) ? KS_OPEN : KS_BARRED;
        default:   st_nx = KS_BARRED;
      endcase
    end else if (prog_done && (st == KS_OPEN)) begin
      st_nx = KS_LOCKED;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= KS_LOCKED;
    else     st <= st_nx;
  end

  assign unlocked = (st == KS_OPEN);
  assign barred   = (st == KS_BARRED);

  // R1: entering the open state requires the second key right after the first
  p_open_needs_keys_r1: assert property (@(posedge clk) disable iff (rst)
    (st == KS_OPEN) && ($past(st) != KS_OPEN) |->
      $past(key_wr && (key_data == KEY_SECOND) && (st == KS_HALF)));

  // R2: barred holds until reset
  p_barred_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (st == KS_BARRED) |=> (st == KS_BARRED));

  // R5: a finished pass leaves the register closed
  p_relock_after_pass_r5: assert property (@(posedge clk) disable iff (rst)
    prog_done |=> (st != KS_OPEN));

endmodule

// File: rtl/optg_prog_engine.sv
`timescale 1ns/1ps
module optg_prog_engine
  import optg_pkg::*;
#(
  parameter int               OPT_W       = 16,
  parameter int               PROG_CYCLES = 16,
  parameter logic [OPT_W-1:0] OPT_DEFAULT = 16'h5AAA
) (
  input  logic             clk,
  input  logic             por_rst,
  input  logic             sys_rst,
  input  logic             unlocked,
  input  logic             ctrl_wr,
  input  logic [OPT_W-1:0] ctrl_data,
  input  logic             ctrl_start,
  output logic [OPT_W-1:0] pending,
  output logic [OPT_W-1:0] stored,
  output logic             busy,
  output logic             prog_done
);

  localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic [OPT_W-1:0] commit_val;

  function automatic logic [OPT_W-1:0] fold(input logic [OPT_W-1:0] cur,
                                            input logic [OPT_W-1:0] req);
    logic [OPT_W-1:0] r;
    r       = req;
    r[7:0]  = merge_prot(cur[7:0], req[7:0]);
    return r;
  endfunction

  assign accept     = ctrl_wr && unlocked && !busy;
  assign prog_done  = busy && (cnt == '0);
  assign commit_val = fold(stored, pending);

  always_ff @(posedge clk) begin
    if (por_rst) begin
      stored  <= OPT_DEFAULT;
      pending <= OPT_DEFAULT;
      busy    <= 1'b0;
      cnt     <= '0;
    end else if (sys_rst) begin
      pending <= stored;
      busy    <= 1'b0;
      cnt     <= '0;
    end else if (prog_done) begin
      stored  <= commit_val;
      busy    <= 1'b0;
    end else if (busy) begin
      cnt     <= cnt - 1'b1;
    end else if (accept) begin
      pending <= ctrl_data;
      if (ctrl_start) begin
        busy <= 1'b1;
        cnt  <= CNT_LOAD;
      end
    end
  end

  // R3: the store moves only on a completing pass
  p_store_only_on_done_r3: assert property (@(posedge clk) disable iff (por_rst)
    !prog_done |=> $stable(stored));

  // R3: busy does not drop before the counter runs out
  p_busy_holds_r3: assert property (@(posedge clk) disable iff (sys_rst)
    busy && !prog_done |=> busy);

  // R4: starts during a pass do not reload the counter
  p_no_restart_r4: assert property (@(posedge clk) disable iff (sys_rst)
    busy && !prog_done |=> (cnt == $past(cnt) - 1'b1));

  // R8: a sealed byte stays sealed
  p_seal_kept_r8: assert property (@(posedge clk) disable iff (por_rst)
    (decode_prot(stored[7:0]) == LVL_SEALED) |=> (stored[7:0] == PROT_SEALED));

endmodule

// File: rtl/optg_prot_decode.sv
`timescale 1ns/1ps
module optg_prot_decode
  import optg_pkg::*;
#(
  parameter int               OPT_W       = 16,
  parameter logic [OPT_W-1:0] OPT_DEFAULT = 16'h5AAA
) (
  input  logic             clk,
  input  logic             por_rst,
  input  logic             sys_rst,
  input  logic [OPT_W-1:0] stored,
  output logic [OPT_W-1:0] active,
  output logic [1:0]       level,
  output logic             dbg_port_en,
  output logic             dbg_flash_en
);

  always_ff @(posedge clk) begin
    if (por_rst)      active <= OPT_DEFAULT;
    else if (sys_rst) active <= stored;
  end

  assign level        = decode_prot(active[7:0]);
  assign dbg_port_en  = (level != LVL_SEALED);
  assign dbg_flash_en = (level == LVL_OPEN);

  // R7: outside reset the active copy is frozen
  p_active_frozen_r7: assert property (@(posedge clk) disable iff (sys_rst)
    !sys_rst |=> $stable(active));

  // R6: a sealed level shuts every debug path
  p_sealed_no_debug_r6: assert property (@(posedge clk) disable iff (sys_rst)
    (level == LVL_SEALED) |-> (!dbg_port_en && !dbg_flash_en));

endmodule

// File: rtl/optg_ctrl.sv
`timescale 1ns/1ps
module optg_ctrl
  import optg_pkg::*;
#(
  parameter int               OPT_W       = 16,
  parameter int               PROG_CYCLES = 16,
  parameter logic [OPT_W-1:0] OPT_DEFAULT = 16'h5AAA
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        sys_rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        busy,
  output logic [1:0]  prot_level,
  output logic        dbg_port_en,
  output logic        dbg_flash_en
);

  logic             por_rst, sys_rst;
  logic             key_wr, ctrl_wr, prog_done;
  logic             unlocked, barred;
  logic [OPT_W-1:0] pending, stored, active;
  logic             unused_bits;

  assign por_rst     = !por_n;
  assign sys_rst     = !por_n || !sys_rst_n;
  assign key_wr      = bus_wr && (bus_addr == RA_KEY);
  assign ctrl_wr     = bus_wr && (bus_addr == RA_CTRL);
  assign unused_bits = ^bus_wdata[START_BIT-1:OPT_W];

  optg_key_seq u_keys (
    .clk       (clk),
    .rst       (sys_rst),
    .key_wr    (key_wr),
    .key_data  (bus_wdata),
    .prog_done (prog_done),
    .unlocked  (unlocked),
    .barred    (barred)
  );

  optg_prog_engine #(
    .OPT_W       (OPT_W),
    .PROG_CYCLES (PROG_CYCLES),
    .OPT_DEFAULT (OPT_DEFAULT)
  ) u_prog (
    .clk        (clk),
    .por_rst    (por_rst),
    .sys_rst    (sys_rst),
    .unlocked   (unlocked),
    .ctrl_wr    (ctrl_wr),
    .ctrl_data  (bus_wdata[OPT_W-1:0]),
    .ctrl_start (bus_wdata[START_BIT]),
    .pending    (pending),
    .stored     (stored),
    .busy       (busy),
    .prog_done  (prog_done)
  );

  optg_prot_decode #(
    .OPT_W       (OPT_W),
    .OPT_DEFAULT (OPT_DEFAULT)
  ) u_dec (
    .clk          (clk),
    .por_rst      (por_rst),
    .sys_rst      (sys_rst),
    .stored       (stored),
    .active       (active),
    .level        (prot_level),
    .dbg_port_en  (dbg_port_en),
    .dbg_flash_en (dbg_flash_en)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      RA_CTRL: bus_rdata[OPT_W-1:0] = pending;
      RA_STAT: bus_rdata[5:0] = {prot_level, 1'b0, barred, unlocked, busy};
      RA_VIEW: begin
        bus_rdata[OPT_W-1:0]  = active;
        bus_rdata[16 +: OPT_W] = stored;
      end
      default: bus_rdata = '0;
    endcase
  end

  // R2: a locked or barred register drops control writes
  p_locked_ignores_r2: assert property (@(posedge clk) disable iff (sys_rst)
    ctrl_wr && !unlocked |=> $stable(pending) && $stable(busy));

endmodule

// File: tb/optg_ctrl_tb.sv
`timescale 1ns/1ps
module optg_ctrl_tb;

  localparam int          PC  = 5;
  localparam logic [15:0] DEF = 16'h5AAA;
  localparam logic [31:0] K1  = 32'h0819_2A3B;
  localparam logic [31:0] K2  = 32'h4C5D_6E7F;
  localparam logic [1:0]  A_KEY = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2, A_VIEW = 2'd3;

  logic        clk = 1'b0, por_n = 1'b0, sys_rst_n = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        busy, dbg_port_en, dbg_flash_en;
  logic [1:0]  prot_level;

  optg_ctrl #(.OPT_W(16), .PROG_CYCLES(PC), .OPT_DEFAULT(DEF)) u_dut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .prot_level(prot_level), .dbg_port_en(dbg_port_en),
    .dbg_flash_en(dbg_flash_en));

  always #2.5 clk = ~clk;

  typedef struct {
    bit          pins;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  bit    rd_req = 1'b0;
  int    n_vec = 0, n_bad = 0;

  // Monitor: compares one queued expectation per requested sample
  always @(negedge clk) begin
    item_t it;
    logic [31:0] act;
    #1;
    if (rd_req) begin
      n_vec++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
      end else begin
        it  = q.pop_front();
        act = it.pins ? {27'd0, busy, dbg_port_en, dbg_flash_en, prot_level} : bus_rdata;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  function automatic logic [1:0] lvl_of(input logic [7:0] b);
    case (b)
      8'hAA:   return 2'd0;
      8'hCC:   return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  function automatic logic [31:0] stat(input bit b, input bit u, input bit x, input logic [1:0] l);
    return {26'd0, l, 1'b0, x, u, b};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    item_t it;
    it.pins = 1'b0; it.exp = e; it.tag = t;
    q.push_back(it);
    bus_addr = a; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic pins(input logic [7:0] pbyte, input bit b, input string t);
    item_t it;
    logic [1:0] l;
    l = lvl_of(pbyte);
    it.pins = 1'b1;
    it.exp  = {27'd0, b, (l != 2'd2), (l == 2'd0), l};
    it.tag  = t;
    q.push_back(it);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic sysrst();
    sys_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    sys_rst_n = 1'b1;
  endtask

  task automatic unlock();
    wr(A_KEY, K1);
    wr(A_KEY, K2);
  endtask

  task automatic program_and_wait(input logic [15:0] v);
    unlock();
    wr(A_CTRL, {1'b1, 15'd0, v});
    repeat (PC + 1) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all-R actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; sys_rst_n = 1'b1;

    // R9 power-on state, R10 map
    rd(A_STAT, stat(0, 0, 0, 2'd0), "R9 status after power-on");
    rd(A_VIEW, {DEF, DEF}, "R9 store and active default");
    rd(A_CTRL, {16'd0, DEF}, "R10 pending equals store");
    pins(DEF[7:0], 0, "R6 level 0 gates");

    // R2 locked writes ignored
    wr(A_CTRL, 32'h8000_1234);
    rd(A_CTRL, {16'd0, DEF}, "R2 locked write ignored");
    rd(A_STAT, stat(0, 0, 0, 2'd0), "R2 no pass started");

    // R2 out-of-order key bars the register
    wr(A_KEY, K2);
    rd(A_STAT, stat(0, 0, 1, 2'd0), "R2 wrong first key bars");
    unlock();
    rd(A_STAT, stat(0, 0, 1, 2'd0), "R2 barred despite good keys");
    wr(A_CTRL, 32'h8000_33BB);
    rd(A_VIEW, {DEF, DEF}, "R2 barred write ignored");
    sysrst();
    rd(A_STAT, stat(0, 0, 0, 2'd0), "R2 reset clears bar");

    // R1 ordering
    wr(A_KEY, K1);
    rd(A_STAT, stat(0, 0, 0, 2'd0), "R1 first key alone stays locked");
    wr(A_KEY, K2);
    rd(A_STAT, stat(0, 1, 0, 2'd0), "R1 unlocked after both keys");

    // R3 pending without start
    wr(A_CTRL, 32'h0000_33BB);
    rd(A_CTRL, 32'h0000_33BB, "R3 pending updated");
    rd(A_VIEW, {DEF, DEF}, "R3 store untouched without start");

    // R3 busy length, R4 start during pass
    wr(A_CTRL, 32'h8000_33BB);
    rd(A_STAT, stat(1, 1, 0, 2'd0), "R3 busy cycle 1");
    wr(A_CTRL, 32'h8000_11CC);
    rd(A_STAT, stat(1, 1, 0, 2'd0), "R3 busy cycle 3");
    rd(A_STAT, stat(1, 1, 0, 2'd0), "R3 busy cycle 4");
    rd(A_STAT, stat(1, 1, 0, 2'd0), "R3 busy cycle 5");
    rd(A_STAT, stat(0, 0, 0, 2'd0), "R5 idle and relocked");
    rd(A_CTRL, 32'h0000_33BB, "R4 write during pass ignored");
    rd(A_VIEW, {16'h33BB, DEF}, "R3 committed R7 active unchanged");
    pins(DEF[7:0], 0, "R7 gates unchanged before reset");
    wr(A_CTRL, 32'h8000_0000);
    rd(A_VIEW, {16'h33BB, DEF}, "R5 write after relock ignored");

    // R7 apply on reset, R6 level 1
    sysrst();
    rd(A_VIEW, {16'h33BB, 16'h33BB}, "R7 active loaded on reset");
    pins(8'hBB, 0, "R6 byte BB gives level 1");
    rd(A_STAT, stat(0, 0, 0, 2'd1), "R10 level field");
    rd(A_CTRL, 32'h0000_33BB, "R10 pending reloads from store");

    // R6 level 2
    program_and_wait(16'h77CC);
    rd(A_VIEW, {16'h77CC, 16'h33BB}, "R3 sealed byte stored");
    sysrst();
    pins(8'hCC, 0, "R6 byte CC gives level 2");

    // R8 seal kept
    program_and_wait(16'h11AA);
    rd(A_VIEW, {16'h11CC, 16'h77CC}, "R8 seal kept user bits commit");
    sysrst();
    pins(8'hCC, 0, "R8 still level 2 after reset");

    // R2 extra key while open
    unlock();
    wr(A_KEY, K1);
    rd(A_STAT, stat(0, 0, 1, 2'd2), "R2 extra key while open bars");

    // R9 power-on restores defaults
    por_n = 1'b0; sys_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1; sys_rst_n = 1'b1;
    rd(A_VIEW, {DEF, DEF}, "R9 power-on restores defaults");
    pins(DEF[7:0], 0, "R9 level 0 after power-on");

    // R1 wrong second key
    wr(A_KEY, K1);
    wr(A_KEY, 32'h0000_0000);
    rd(A_STAT, stat(0, 0, 1, 2'd0), "R1 wrong second key does not open");
    sysrst();

    // R6 catch-all and return to level 0
    program_and_wait(16'h4400);
    sysrst();
    pins(8'h00, 0, "R6 byte 00 gives level 1");
    rd(A_VIEW, {16'h4400, 16'h4400}, "R7 catch-all applied");
    program_and_wait(16'h21AA);
    sysrst();
    pins(8'hAA, 0, "R6 byte AA back to level 0");

    repeat (2) @(negedge clk);
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule